// File: doc/BRIEF.md
# Dual-Bus CAN Repeater Core Logic

This block is the digital heart of a transceiver that joins one protocol controller to two CAN bus segments, or bridges two segments to each other. It takes one synchronised receive level per bus, a local transmit level and an expansion input from a neighbouring device. It produces one transmitter drive level per bus, a local receive level and an expansion output. Every signal at its edge is active low: low means dominant and high means recessive. A dominant level from any source reaches every bus and every output, so bitwise arbitration spans both segments.

A bus that this block is driving reads back its own dominant level. The block therefore masks that bus's receiver while it drives the bus, and keeps the mask for a hold window after it lets go, so the echo cannot re-trigger the bridge. A bus that is itself dominant from outside is never driven from the other side, which keeps its release visible. When such a release happens, any new bridging drive onto that bus is held off for a short lockout. Each bus has an active-high disable that silences its receiver and its transmitter. The local receive level keeps following the local and expansion inputs while both buses are disabled. The analog comparators, slope control and drivers lie outside the block, and every interval is a number of clock cycles. The control inputs are defined so that a high level is the idle or disabled value, which is the level that pull-ups give an open pin.

Top module: `dual_bus_repeater`

## Requirements
- R1: After reset, with local_tx, expand_in and rx_bus all high and bus_dis at 0, tx_bus is 2'b11 and local_rx and expand_out are high.
- R2: local_tx low pulls local_rx and expand_out low in the same cycle. It drives both tx_bus bits low from the next clock edge on.
- R3: expand_in low drives both tx_bus bits low from the next clock edge and pulls local_rx low in the same cycle. expand_out stays high. expand_in high changes nothing.
- R4: For either bus i, rx_bus[i] low, when that bus is not masked, pulls expand_out and local_rx low after SYNC_STAGES clock edges. One edge later it drives the other bus's tx_bus bit low, and tx_bus[i] stays high. The two buses behave identically.
- R5: bus_dis[i] high forces tx_bus[i] high in the same cycle and makes rx_bus[i] have no effect on any output. local_rx still follows local_tx and expand_in.
- R6: While tx_bus[i] is low, and for HOLD_CYC cycles after the drive ends, a low level on rx_bus[i] does not reach expand_out, local_rx or the other bus.
- R7: A single dominant pulse on one bus ends with every output back at recessive, and they stay there without oscillating.
- R8: When rx_bus[i] returns high while the other bus stays dominant, tx_bus[i] first goes low LOCK_CYC + SYNC_STAGES + 2 cycles after the input change, not SYNC_STAGES + 1.
- R9: A bus that reads dominant and is not masked is not driven because of the other bus. If both buses go dominant together, tx_bus stays 2'b11.
- R10: With two buses held dominant from outside and released at different times, in either order, expand_out and local_rx stay low until the last release and show no low pulse after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bus | input | 2 | Comparator level of each bus, low = dominant, asynchronous |
| bus_dis | input | 2 | Per-bus disable, high = receiver and transmitter of that bus off |
| local_tx | input | 1 | Transmit level from the protocol controller, low = dominant |
| expand_in | input | 1 | Expansion input from a neighbouring device, low = dominant |
| tx_bus | output | 2 | Drive level of each bus transmitter, low = drive dominant |
| local_rx | output | 1 | Receive level to the protocol controller, low = dominant |
| expand_out | output | 1 | Expansion output to a neighbouring device, low = dominant |

## Verification
The bench closes the loop the way a real segment does: each rx_bus line is the wired-AND of an outside node and the block's own tx_bus. This means every echo and hold-window effect really occurs. Local and expansion drives tell the direct paths apart from the bridged paths. A lone pulse on each bus in turn shows that the repeater is symmetric and that the echo dies away. Two buses asserted together and then released in both orders separate the mask-based behaviour from the lockout and the no-drive-onto-a-source rule. Disabled buses combined with local drive show that the receive path to the controller does not depend on the enables.

// File: rtl/canrep_pkg.sv
package canrep_pkg;

  localparam int NBUS   = 2;
  localparam int TICK_W = 8;

  typedef logic [TICK_W-1:0] tick_t;

  // Down-counter step: reload on load, otherwise count down and stop at zero.
  function automatic tick_t tick_next(logic load, tick_t load_val, tick_t cur);
    if (load) return load_val;
    if (cur != '0) return cur - tick_t'(1);
    return '0;
  endfunction

  // Expansion output level: any bus seen dominant, or the local transmitter.
  function automatic logic exp_level(logic [NBUS-1:0] seen, logic loc_tx_n);
    return ~((|seen) | ~loc_tx_n);
  endfunction

  // Local receive level: the expansion level plus the expansion input.
  function automatic logic loc_level(logic [NBUS-1:0] seen, logic loc_tx_n,
                                     logic exp_in_n);
    return ~((|seen) | ~loc_tx_n | ~exp_in_n);
  endfunction

endpackage

// File: rtl/rep_sync.sv
module rep_sync #(
  parameter int           W       = 2,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rep_lane.sv
module rep_lane
  import canrep_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int LOCK_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_off,    // high: this bus disabled
  input  logic line_n,     // synchronised bus level, low = dominant
  input  logic peer_dom,   // other bus seen dominant (after its mask)
  input  logic local_dom,  // local or expansion drive request
  output logic seen_dom,   // this bus seen dominant after masking
  output logic drive_on    // this bus's transmitter driving dominant
);
  tick_t hold_q, lock_q;
  logic  drv_q, seen_q;

  // Named internal events
  logic rcv_dom, supp_on, release_ev, lock_on, bridge_req, drive_req;

  assign rcv_dom    = ~bus_off & ~line_n;
  assign supp_on    = drv_q | (hold_q != '0);
  assign seen_dom   = rcv_dom & ~supp_on;
  assign release_ev = seen_q & ~rcv_dom;
  assign lock_on    = release_ev | (lock_q != '0);
  assign bridge_req = peer_dom & ~seen_dom & (drv_q | ~lock_on);
  assign drive_req  = ~bus_off & (local_dom | bridge_req);
  assign drive_on   = drv_q & ~bus_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      lock_q <= '0;
      drv_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hold_q <= tick_next(drv_q, tick_t'(HOLD_CYC), hold_q);
      lock_q <= tick_next(release_ev, tick_t'(LOCK_CYC), lock_q);
      drv_q  <= drive_req;
      seen_q <= seen_dom;
    end
  end

  // R6: the mask is still on in the cycle after the drive ends
  assert_hold_after_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_CYC > 0) && $fell(drv_q) |-> supp_on)
    else $error("hold window missing after drive release");

  // R8: a fresh release blocks a bridging drive in the next cycle
  assert_lockout_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev && !drv_q && !local_dom |=> !drv_q)
    else $error("bridge drive started inside lockout");

  // R9: a bus seen dominant is not driven from the peer
  assert_no_drive_onto_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_dom && !local_dom |=> !drv_q)
    else $error("source bus was driven from the peer");

  // R5: a disabled bus never starts driving
  assert_disabled_stays_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> !drv_q)
    else $error("disabled bus started driving");
endmodule

// File: rtl/dual_bus_repeater.sv
module dual_bus_repeater
  import canrep_pkg::*;
#(
  parameter int HOLD_CYC    = 4,
  parameter int LOCK_CYC    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUS-1:0] rx_bus,
  input  logic [NBUS-1:0] bus_dis,
  input  logic            local_tx,
  input  logic            expand_in,
  output logic [NBUS-1:0] tx_bus,
  output logic            local_rx,
  output logic            expand_out
);
  logic [NBUS-1:0] line_s;
  logic [NBUS-1:0] seen_dom;
  logic [NBUS-1:0] drive_on;
  logic            local_dom;

  assign local_dom = ~local_tx | ~expand_in;

  rep_sync #(.W(NBUS), .STAGES(SYNC_STAGES), .RST_VAL({NBUS{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_bus),
    .q     (line_s)
  );

  for (genvar g = 0; g < NBUS; g++) begin : g_lane
    localparam int PEER = NBUS - 1 - g;

    rep_lane #(.HOLD_CYC(HOLD_CYC), .LOCK_CYC(LOCK_CYC)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_off   (bus_dis[g]),
      .line_n    (line_s[g]),
      .peer_dom  (seen_dom[PEER]),
      .local_dom (local_dom),
      .seen_dom  (seen_dom[g]),
      .drive_on  (drive_on[g])
    );

    assign tx_bus[g] = ~drive_on[g];

    // R5: a disabled bus shows recessive drive
    assert_disabled_tx_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dis[g] |-> tx_bus[g])
      else $error("disabled bus drives dominant");
  end

  assign expand_out = exp_level(seen_dom, local_tx);
  assign local_rx   = loc_level(seen_dom, local_tx, expand_in);

  // R2: local drive reaches both enabled buses one edge later
  assert_local_drives_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!local_tx && bus_dis == '0) && bus_dis == '0 |-> tx_bus == '0)
    else $error("local dominant not forwarded to both buses");

  // R3: expansion input reaches the local receiver
  assert_expand_in_to_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !expand_in |-> !local_rx)
    else $error("expansion dominant not seen on local receive");
endmodule

// File: tb/dual_bus_repeater_test.sv
`timescale 1ns/1ps
module dual_bus_repeater_test;
  localparam int HOLD = 4;
  localparam int LOCK = 5;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] b_ext = 2'b11;
  logic [1:0] b_dis = 2'b00;
  logic       b_tx0 = 1'b1;
  logic       b_text = 1'b1;
  logic [1:0] rx_line;
  logic [1:0] tx_bus;
  logic       local_rx, expand_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  assign rx_line = b_ext & tx_bus;   // wired-AND of outside node and own driver

  dual_bus_repeater #(.HOLD_CYC(HOLD), .LOCK_CYC(LOCK), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .rx_bus(rx_line), .bus_dis(b_dis),
    .local_tx(b_tx0), .expand_in(b_text),
    .tx_bus(tx_bus), .local_rx(local_rx), .expand_out(expand_out)
  );

  // ---------------- behavioural reference model ----------------
  bit m_sh[2][SYNC];
  bit m_drv[2];
  int m_hold[2];
  int m_lock[2];
  bit m_prev[2];

  function automatic bit m_rcv(int i);
    return !b_dis[i] && !m_sh[i][SYNC-1];
  endfunction
  function automatic bit m_eff(int i);
    return m_rcv(i) && !(m_drv[i] || m_hold[i] > 0);
  endfunction
  function automatic bit m_want(int i);
    bit loc, blocked, br;
    loc = !b_tx0 || !b_text;
    blocked = (m_prev[i] && !m_rcv(i)) || (m_lock[i] > 0);
    br = m_eff(1-i) && !m_eff(i) && (m_drv[i] || !blocked);
    return !b_dis[i] && (loc || br);
  endfunction

  always @(posedge clk) begin
    bit w[2], r[2], e[2], ln[2];
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        for (int k = 0; k < SYNC; k++) m_sh[i][k] = 1'b1;
        m_drv[i] = 0; m_hold[i] = 0; m_lock[i] = 0; m_prev[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        w[i] = m_want(i); r[i] = m_rcv(i); e[i] = m_eff(i);
        ln[i] = b_ext[i] && !(m_drv[i] && !b_dis[i]);
      end
      for (int i = 0; i < 2; i++) begin
        m_hold[i] = m_drv[i] ? HOLD : (m_hold[i] > 0 ? m_hold[i] - 1 : 0);
        m_lock[i] = (m_prev[i] && !r[i]) ? LOCK : (m_lock[i] > 0 ? m_lock[i] - 1 : 0);
        m_prev[i] = e[i];
        m_drv[i]  = w[i];
        for (int k = SYNC - 1; k > 0; k--) m_sh[i][k] = m_sh[i][k-1];
        m_sh[i][0] = ln[i];
      end
    end
  end

  always @(negedge clk) begin
    logic [3:0] expv, actv;
    if (rst_n && !done) begin
      expv[3] = !(m_drv[1] && !b_dis[1]);
      expv[2] = !(m_drv[0] && !b_dis[0]);
      expv[1] = !(m_eff(0) || m_eff(1) || !b_tx0 || !b_text);
      expv[0] = !(m_eff(0) || m_eff(1) || !b_tx0);
      actv = {tx_bus, local_rx, expand_out};
      total++;
      if (actv !== expv) begin
        bad++;
        $display("FAIL R2 R4 R6 R8 model compare t=%0t actual=%b expected=%b", $time, actv, expv);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  // counts negedges where any output is not recessive
  task automatic quiet(input int n, input string req);
    int noisy = 0;
    for (int k = 0; k < n; k++) begin
      at_neg();
      if ({tx_bus, local_rx, expand_out} !== 4'b1111) noisy++;
    end
    check(req, noisy, 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first, highs, lows;
    tick(4);
    rst_n = 1'b1;
    tick(3);

    // R1 idle after reset
    at_neg();
    check("R1 tx_bus idle", tx_bus, 2'b11);
    check("R1 local_rx idle", local_rx, 1);
    check("R1 expand_out idle", expand_out, 1);

    // R2 local transmit
    tick(); b_tx0 = 1'b0;
    at_neg();
    check("R2 local_rx same cycle", local_rx, 0);
    check("R2 expand_out same cycle", expand_out, 0);
    check("R2 tx_bus before edge", tx_bus, 2'b11);
    at_neg();
    check("R2 tx_bus after one edge", tx_bus, 2'b00);
    tick(4); b_tx0 = 1'b1;
    tick(8);
    quiet(5, "R2 release back to idle");

    // R3 expansion input
    tick(); b_text = 1'b0;
    at_neg();
    check("R3 local_rx same cycle", local_rx, 0);
    check("R3 expand_out unaffected", expand_out, 1);
    at_neg();
    check("R3 tx_bus after one edge", tx_bus, 2'b00);
    tick(4); b_text = 1'b1;
    tick(8);
    quiet(5, "R3 high has no effect");

    // R4 / R7 single pulse on each bus
    for (int b = 0; b < 2; b++) begin
      tick(); b_ext[b] = 1'b0;
      at_neg(); at_neg();
      check($sformatf("R4 bus%0d expand_out before sync", b), expand_out, 1);
      at_neg();
      check($sformatf("R4 bus%0d expand_out after sync", b), expand_out, 0);
      check($sformatf("R4 bus%0d local_rx after sync", b), local_rx, 0);
      at_neg();
      check($sformatf("R4 bus%0d tx_bus bridged", b), tx_bus, (b == 0) ? 2'b01 : 2'b10);
      tick(8); b_ext[b] = 1'b1;
      tick(8);
      quiet(25, $sformatf("R7 bus%0d pulse settles", b));
    end

    // R5 disable
    b_dis = 2'b10;
    tick(); b_tx0 = 1'b0;
    at_neg();
    check("R5 disabled tx high at once", tx_bus[1], 1);
    check("R5 local_rx follows local_tx", local_rx, 0);
    at_neg();
    check("R5 enabled bus driven", tx_bus, 2'b10);
    tick(); b_tx0 = 1'b1; b_ext[1] = 1'b0;
    tick(6);
    at_neg();
    check("R5 disabled receiver ignored", expand_out, 1);
    check("R5 enabled bus not driven by disabled one", tx_bus, 2'b11);
    b_ext = 2'b11; b_dis = 2'b11;
    tick(); b_text = 1'b0;
    at_neg();
    check("R5 local_rx with both disabled", local_rx, 0);
    check("R5 tx_bus with both disabled", tx_bus, 2'b11);
    tick(); b_text = 1'b1; b_dis = 2'b00;
    tick(8);

    // R6 echo and outside pulse on a driven bus are masked
    tick(); b_tx0 = 1'b0;
    tick(3); b_ext[1] = 1'b0;
    tick(3); b_ext[1] = 1'b1;
    tick(2); b_tx0 = 1'b1;
    lows = 0;
    for (int k = 0; k < 12; k++) begin
      at_neg();
      if (!expand_out || !local_rx) lows++;
    end
    check("R6 masked bus gives no low after release", lows, 0);
    tick(6);

    // R9 both together, then R8 lockout with bus0 released first
    tick(); b_ext = 2'b00;
    tick(6);
    at_neg();
    check("R9 neither source driven", tx_bus, 2'b11);
    check("R9 expand_out low", expand_out, 0);
    tick(); b_ext[0] = 1'b1;
    first = -1; highs = 0;
    for (int n = 0; n < LOCK + 8; n++) begin
      at_neg();
      if (first < 0 && !tx_bus[0]) first = n;
      if (expand_out) highs++;
    end
    check("R8 bridge delay after release", first, LOCK + SYNC + 2);
    check("R10 expand_out held low through handover", highs, 0);
    tick(); b_ext[1] = 1'b1;
    tick(8);
    quiet(25, "R10 no pulse after last release");

    // R9 then R8 with bus1 released first (symmetry)
    tick(); b_ext = 2'b00;
    tick(6);
    tick(); b_ext[1] = 1'b1;
    first = -1;
    for (int n = 0; n < LOCK + 8; n++) begin
      at_neg();
      if (first < 0 && !tx_bus[1]) first = n;
    end
    check("R8 bus1 bridge delay", first, LOCK + SYNC + 2);
    tick(); b_ext[0] = 1'b1;
    tick(8);
    quiet(25, "R10 bus1-first no pulse after release");

    // R10 staggered onset, driven bus released first
    tick(); b_ext[0] = 1'b0;
    tick(5); b_ext[1] = 1'b0;
    tick(6); b_ext[1] = 1'b1;
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      at_neg();
      if (expand_out || local_rx) highs++;
    end
    check("R10 outputs held low before last release", highs, 0);
    tick(); b_ext[0] = 1'b1;
    at_neg(); at_neg(); at_neg();
    check("R10 expand_out high after last release", expand_out, 1);
    tick(6);
    quiet(25, "R10 staggered no spurious low");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule